// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of single-bit lock tokens that two agents, called the left port and the right port, use to agree on who may touch a shared resource. Both ports run on one clock. On each rising edge a port may issue one strobe: a write or a read, aimed at one of the tokens by a 3-bit index.

To ask for a token a port writes 0. To give it back, or to withdraw a request it made earlier, the port writes 1. A read returns 0 when the reading port holds the addressed token and 1 in every other case. If a port asks for a token that the other side already holds, its request is kept. When the holder lets go, the token moves straight to the waiting port, so the waiting port never has to race to claim it.

Top module: `sem_bank`

## Requirements
- R1: The bank holds eight tokens that change state independently of one another. The 3-bit index on a port selects the token, and a strobe on one token never changes the state of another.
- R2: A port strobe with select high and write enable high is a write. Data value 0 is a request and data value 1 is a release or a cancel. A strobe with select high and write enable low is a read. With select low the port is idle.
- R3: A request for a free token makes the requesting port its owner. From then on the owner reads 0 at that index and the other port reads 1.
- R4: A request from the non-owner for a held token leaves the ownership unchanged, and both ports keep reading the same values as before. The request is kept as pending.
- R5: When the owner releases a token while the other port has a request pending, ownership passes to the waiting port at that same clock edge.
- R6: When the owner releases a token and no request is pending from the other port, the token becomes free and both ports read 1.
- R7: Read data is 9 bits wide, and all nine bits carry the same state bit: 9'h000 when the port owns the token and 9'h1FF otherwise.
- R8: When both ports request the same free token at the same edge, the left port becomes the owner and the right port's request stays pending.
- R9: Read data appears from a per-port register one cycle after the read strobe and holds its value until that port's next read. A write by the opposite port at the same edge as the read does not change the value captured.
- R10: Reset is synchronous and active low. It frees all eight tokens, clears every pending request and sets both read registers to 9'h1FF.
- R11: A release written by the non-owner cancels that port's pending request. When the owner later releases the token, it becomes free instead of passing to the port that cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left port strobe select |
| l_wr | input | 1 | Left port write enable (1 write, 0 read) |
| l_addr | input | 3 | Left port token index |
| l_wdat | input | 1 | Left port write data (0 request, 1 release) |
| l_rdat | output | 9 | Left port registered read data |
| r_sel | input | 1 | Right port strobe select |
| r_wr | input | 1 | Right port write enable (1 write, 0 read) |
| r_addr | input | 3 | Right port token index |
| r_wdat | input | 1 | Right port write data (0 request, 1 release) |
| r_rdat | output | 9 | Right port registered read data |

## Verification
The token exchange is driven with four kinds of pattern: a lone port taking and releasing a token, the non-owner queueing behind the holder, both ports requesting the same free token at the same edge, and a request that is cancelled before the holder lets go. Each pattern separates a different path through the handover logic. The left-priority rule is visible only in the same-edge pattern. The cancel pattern tells a request that was kept apart from one that was dropped. A read taken at the same edge as a handover shows whether the read register samples the token state before or after the update. Work on two tokens at once shows whether the index decode keeps them apart.

// File: rtl/sem_bank_pkg.sv
// Package: sem_bank_pkg
// Types and constants shared by the semaphore bank modules.
// Assumes: a single clock domain for both ports.
package sem_bank_pkg;

    // Token ownership state kept for each semaphore
    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_owner_e;

    // Port strobe classes after decoding
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's strobe (select, write enable, index, data bit) into
// one-hot request and release vectors over the token bank, plus a read strobe.
// Assumes: the index is always in range (NUM_SEM is a power of two).
module sem_port_decode
    import sem_bank_pkg::*;
#(
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wdat,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel,
    output logic               rd
);

    port_op_e op;

    // Classify the strobe
    always_comb begin
        if (!sel)     op = OP_IDLE;
        else if (wr)  op = OP_WRITE;
        else          op = OP_READ;
    end

    assign rd = (op == OP_READ);

    // One request/release line per token, selected by the index
    for (genvar g = 0; g < NUM_SEM; g++) begin : g_line
        logic hit;
        assign hit    = (op == OP_WRITE) && (idx == IDX_W'(g));
        assign req[g] = hit && !wdat;
        assign rel[g] = hit &&  wdat;
    end

endmodule

// File: rtl/sem_cell.sv
// Module: sem_cell
// One semaphore token: owner state plus a pending-request flag per port.
// A request for a held token is queued. A release passes the token to a
// queued requester in the same edge. Same-edge requests on a free token
// go to the left port.
// Assumes: req and rel of one port are never both high (one strobe per port).
module sem_cell
    import sem_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own
);

    tok_owner_e own_q, own_d;
    logic       pend_l_q, pend_l_d;
    logic       pend_r_q, pend_r_d;

    // Next-state for owner and pending flags
    always_comb begin
        own_d    = own_q;
        pend_l_d = pend_l_q;
        pend_r_d = pend_r_q;
        unique case (own_q)
            TOK_LEFT: begin
                pend_l_d = 1'b0;
                if (l_rel) begin
                    if (r_req || (pend_r_q && !r_rel)) own_d = TOK_RIGHT;
                    else                                own_d = TOK_FREE;
                    pend_r_d = 1'b0;
                end else if (r_req) begin
                    pend_r_d = 1'b1;
                end else if (r_rel) begin
                    pend_r_d = 1'b0;
                end
            end
            TOK_RIGHT: begin
                pend_r_d = 1'b0;
                if (r_rel) begin
                    if (l_req || (pend_l_q && !l_rel)) own_d = TOK_LEFT;
                    else                                own_d = TOK_FREE;
                    pend_l_d = 1'b0;
                end else if (l_req) begin
                    pend_l_d = 1'b1;
                end else if (l_rel) begin
                    pend_l_d = 1'b0;
                end
            end
            default: begin
                pend_l_d = 1'b0;
                pend_r_d = 1'b0;
                if (l_req) begin
                    own_d    = TOK_LEFT;
                    pend_r_d = r_req;
                end else if (r_req) begin
                    own_d    = TOK_RIGHT;
                end
            end
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= TOK_FREE;
            pend_l_q <= 1'b0;
            pend_r_q <= 1'b0;
        end else begin
            own_q    <= own_d;
            pend_l_q <= pend_l_d;
            pend_r_q <= pend_r_d;
        end
    end

    assign l_own = (own_q == TOK_LEFT);
    assign r_own = (own_q == TOK_RIGHT);

    // Same-edge requests on a free token: left wins
    assert_grant_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_FREE && l_req) |=> (own_q == TOK_LEFT));

    // Losing right request stays queued
    assert_loser_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_FREE && l_req && r_req) |=> pend_r_q);

    // Queued request is taken over on release
    assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_LEFT && l_rel && pend_r_q && !r_rel) |=> (own_q == TOK_RIGHT));

    // Release with nobody waiting frees the token
    assert_release_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_RIGHT && r_rel && !pend_l_q && !l_req) |=> (own_q == TOK_FREE));

    // Holder keeps the token unless it releases
    assert_holder_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_LEFT && !l_rel) |=> (own_q == TOK_LEFT));

    // Cancelled request does not linger
    assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == TOK_LEFT && r_rel && !l_rel) |=> !pend_r_q);

    // Reset frees the token and clears both queues
    assert_reset_free_R10: assert property (@(posedge clk)
        !rst_n |=> (own_q == TOK_FREE && !pend_l_q && !pend_r_q));

endmodule

// File: rtl/sem_read_port.sv
// Module: sem_read_port
// Per-port read register: on a read strobe it captures whether this port
// owns the addressed token and fans the bit out across the read bus.
// Assumes: own_vec reflects the token state before this edge's writes.
module sem_read_port #(
    parameter int NUM_SEM = 8,
    parameter int RD_W    = 9,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [RD_W-1:0]    rdat
);

    // Capture inverted ownership on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)  rdat <= {RD_W{1'b1}};
        else if (rd) rdat <= {RD_W{~own_vec[idx]}};
    end

    // All read bits agree
    assert_rdat_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdat == {RD_W{1'b0}}) || (rdat == {RD_W{1'b1}}));

    // Read register holds between reads
    assert_rdat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdat));

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank
// Top of the two-port semaphore bank: decodes both ports, instantiates one
// sem_cell per token and a registered read path for each port.
// Assumes: both ports share clk; one strobe per port per cycle.
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int RD_W    = 9,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic             l_wr,
    input  logic [IDX_W-1:0] l_addr,
    input  logic             l_wdat,
    output logic [RD_W-1:0]  l_rdat,
    input  logic             r_sel,
    input  logic             r_wr,
    input  logic [IDX_W-1:0] r_addr,
    input  logic             r_wdat,
    output logic [RD_W-1:0]  r_rdat
);

    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] l_own, r_own;
    logic               l_rd, r_rd;

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .idx(l_addr), .wdat(l_wdat),
        .req(l_req), .rel(l_rel), .rd(l_rd)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .idx(r_addr), .wdat(r_wdat),
        .req(r_req), .rel(r_rel), .rd(r_rd)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_tok
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_own(l_own[g]), .r_own(r_own[g])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd(l_rd), .idx(l_addr),
        .own_vec(l_own), .rdat(l_rdat)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd(r_rd), .idx(r_addr),
        .own_vec(r_own), .rdat(r_rdat)
    );

    // At most one port owns any token
    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0);

    // Only a write strobe on a token can change its ownership
    assert_untouched_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_req | l_rel | r_req | r_rel) == '0) |=> ($stable(l_own) && $stable(r_own)));

endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;

    localparam logic [1:0] NO = 2'd0;
    localparam logic [1:0] RD = 2'd1;
    localparam logic [1:0] WR = 2'd2;

    typedef struct packed {
        logic [1:0] lop; logic [2:0] la; logic ld;
        logic [1:0] rop; logic [2:0] ra; logic rd;
        logic el; logic er;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{WR,3'd0,1'b0, NO,3'd0,1'b0, 1'b0,1'b0}, //  0 R3 left takes token 0
        '{RD,3'd0,1'b0, RD,3'd0,1'b0, 1'b0,1'b1}, //  1 R3 R7 owner 0, other 1
        '{NO,3'd0,1'b0, WR,3'd0,1'b0, 1'b0,1'b0}, //  2 R4 right queues
        '{RD,3'd0,1'b0, RD,3'd0,1'b0, 1'b0,1'b1}, //  3 R4 no visible change
        '{WR,3'd0,1'b1, NO,3'd0,1'b0, 1'b0,1'b0}, //  4 R5 left releases
        '{RD,3'd0,1'b0, RD,3'd0,1'b0, 1'b1,1'b0}, //  5 R5 right now owns
        '{NO,3'd0,1'b0, WR,3'd0,1'b1, 1'b0,1'b0}, //  6 R6 right releases
        '{RD,3'd0,1'b0, RD,3'd0,1'b0, 1'b1,1'b1}, //  7 R6 free
        '{WR,3'd3,1'b0, WR,3'd3,1'b0, 1'b0,1'b0}, //  8 R8 same-edge requests
        '{RD,3'd3,1'b0, RD,3'd3,1'b0, 1'b0,1'b1}, //  9 R8 left wins
        '{WR,3'd3,1'b1, NO,3'd0,1'b0, 1'b0,1'b0}, // 10 R8 left releases
        '{RD,3'd3,1'b0, RD,3'd3,1'b0, 1'b1,1'b0}, // 11 R8 right request was kept
        '{NO,3'd0,1'b0, WR,3'd5,1'b0, 1'b0,1'b0}, // 12 R1 right takes token 5
        '{RD,3'd5,1'b0, RD,3'd3,1'b0, 1'b1,1'b0}, // 13 R1 token 3 still right's
        '{RD,3'd0,1'b0, RD,3'd5,1'b0, 1'b1,1'b0}, // 14 R1 token 0 untouched
        '{WR,3'd5,1'b0, NO,3'd0,1'b0, 1'b0,1'b0}, // 15 R11 left queues on 5
        '{WR,3'd5,1'b1, NO,3'd0,1'b0, 1'b0,1'b0}, // 16 R11 left cancels
        '{NO,3'd0,1'b0, WR,3'd5,1'b1, 1'b0,1'b0}, // 17 R11 right releases
        '{RD,3'd5,1'b0, RD,3'd5,1'b0, 1'b1,1'b1}, // 18 R11 token free
        '{NO,3'd0,1'b0, WR,3'd3,1'b1, 1'b0,1'b0}, // 19 R2 release token 3
        '{RD,3'd3,1'b0, RD,3'd3,1'b0, 1'b1,1'b1}, // 20 R2 free
        '{WR,3'd6,1'b0, NO,3'd0,1'b0, 1'b0,1'b0}, // 21 R9 left takes 6
        '{NO,3'd0,1'b0, WR,3'd6,1'b0, 1'b0,1'b0}, // 22 R9 right queues
        '{WR,3'd6,1'b1, RD,3'd6,1'b0, 1'b0,1'b1}, // 23 R9 read at handover edge sees old
        '{RD,3'd6,1'b0, RD,3'd6,1'b0, 1'b1,1'b0}  // 24 R9 next read sees new
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 1'b0, l_wr = 1'b0, l_wdat = 1'b0;
    logic [2:0] l_addr = '0;
    logic       r_sel = 1'b0, r_wr = 1'b0, r_wdat = 1'b0;
    logic [2:0] r_addr = '0;
    logic [8:0] l_rdat, r_rdat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sem_bank uut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdat(l_wdat), .l_rdat(l_rdat),
        .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdat(r_wdat), .r_rdat(r_rdat)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one strobe per port for one edge, then sample just after it
    task automatic step(input logic [1:0] lop, input logic [2:0] la, input logic ld,
                        input logic [1:0] rop, input logic [2:0] ra, input logic rd);
        l_sel = (lop != NO); l_wr = (lop == WR); l_addr = la; l_wdat = ld;
        r_sel = (rop != NO); r_wr = (rop == WR); r_addr = ra; r_wdat = rd;
        @(posedge clk); #1;
        l_sel = 1'b0; r_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state of read registers
        check("R10 left reset", l_rdat, 9'h1FF);
        check("R10 right reset", r_rdat, 9'h1FF);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].lop, VEC[i].la, VEC[i].ld, VEC[i].rop, VEC[i].ra, VEC[i].rd);
            if (VEC[i].lop == RD)
                check($sformatf("R7 table row %0d left", i), l_rdat, {9{VEC[i].el}});
            if (VEC[i].rop == RD)
                check($sformatf("R7 table row %0d right", i), r_rdat, {9{VEC[i].er}});
        end

        // R9 hold: right owns 6; opposite writes and idle cycles leave rdat alone
        step(NO,3'd0,1'b0, RD,3'd6,1'b0);
        check("R9 right read 6", r_rdat, 9'h000);
        step(WR,3'd6,1'b0, NO,3'd0,1'b0);
        step(NO,3'd0,1'b0, WR,3'd6,1'b1);
        step(NO,3'd0,1'b0, NO,3'd0,1'b0);
        check("R9 right held", r_rdat, 9'h000);
        step(NO,3'd0,1'b0, RD,3'd6,1'b0);
        check("R5 right released to queued left", r_rdat, 9'h1FF);
        step(RD,3'd6,1'b0, NO,3'd0,1'b0);
        check("R5 left owns 6", l_rdat, 9'h000);

        // R10 reset mid-operation: left owns 1 and 6, right queued on 1
        step(WR,3'd1,1'b0, NO,3'd0,1'b0);
        step(NO,3'd0,1'b0, WR,3'd1,1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10 left rdat after reset", l_rdat, 9'h1FF);
        rst_n = 1'b1;
        step(RD,3'd1,1'b0, RD,3'd6,1'b0);
        check("R10 token 1 freed", l_rdat, 9'h1FF);
        check("R10 token 6 freed", r_rdat, 9'h1FF);
        // No stale queue: right takes 1 freshly, left release has no effect
        step(NO,3'd0,1'b0, WR,3'd1,1'b0);
        step(WR,3'd1,1'b1, RD,3'd1,1'b0);
        check("R10 right took 1", r_rdat, 9'h000);
        step(RD,3'd1,1'b0, RD,3'd1,1'b0);
        check("R11 stray release ignored left", l_rdat, 9'h1FF);
        check("R11 stray release ignored right", r_rdat, 9'h000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule